// File: doc/BRIEF.md
# Frame Offset Measurement Unit

This unit measures how far a frame-evaluation input lags the 8 kHz frame pulse, counted in half-periods of the serial master clock. It also works out on its own which frame-pulse convention is in use. An active-low pulse on a line that idles high selects the ST-BUS convention. An active-high pulse on a line that idles low selects the GCI convention. The detected convention sets which edge of each input counts as its reference: falling edges for ST-BUS and rising edges for GCI.

The unit runs on a clock at twice the serial bit-clock rate, so one cycle is one master-clock half-period. A frame lasts `FRAME_LEN` cycles. Software arms a measurement by holding the start bit low for at least one frame and then raising it. The unit waits for the next reference frame edge. It then counts cycles until the selected evaluation edge arrives and holds the result. The completion flag rises at the second reference frame edge after the start bit rose. Lowering the start bit clears the flag and allows a new measurement.

The control is one state machine with these states:
- `ST_BLOCKED`: start is high but the unit is not armed.
- `ST_COUNT_LOW`: start is low and the unit is counting low cycles.
- `ST_ARMED`: start has been low long enough.
- `ST_SYNC`: waiting for the first frame edge.
- `ST_MEASURE`: counting toward the evaluation edge.
- `ST_HOLD`: result captured, waiting for the closing frame edge.
- `ST_DONE`: flag raised.

Its transitions are:
- BLOCKED→COUNT_LOW when start falls.
- COUNT_LOW→BLOCKED when start rises too early.
- COUNT_LOW→ARMED after `FRAME_LEN` low cycles.
- ARMED→SYNC when start rises.
- SYNC→MEASURE at a frame edge.
- SYNC→HOLD at a frame edge that coincides with an evaluation edge.
- MEASURE→HOLD at the evaluation edge.
- MEASURE→DONE at a frame edge.
- HOLD→DONE at a frame edge.
- SYNC, MEASURE, HOLD or DONE→COUNT_LOW when start falls. From SYNC, MEASURE or HOLD this aborts the measurement.

Top module: `fom_unit`

## Requirements
- R1: Over each window of `FRAME_LEN` cycles counted from reset, `fmt_gci` becomes 0 (ST-BUS) if the sampled frame pulse was high in more than half the cycles. It becomes 1 (GCI) if it was high in fewer than half.
- R2: A window with exactly half of its samples high leaves `fmt_gci` unchanged.
- R3: A rise of `start_eval` launches a measurement only if `start_eval` was low for at least `FRAME_LEN` consecutive cycles before it. After a shorter low period the rise is ignored, and `start_eval` must go low again.
- R4: `done` rises `SAMPLE_STAGES`+1 cycles after the second reference frame edge following the start rise appears on `fp_in`. With the default of one sampling stage this is two cycles.
- R5: `offset[10:0]` holds the number of cycles from the first reference frame edge after the start rise to the selected evaluation edge within the following frame. In this case `offset[11]` is 0.
- R6: In ST-BUS mode the falling edges of `fp_in` and `fe_in` are the reference edges. In GCI mode the rising edges are. An edge of the other polarity is not counted.
- R7: If no selected evaluation edge arrives before the next reference frame edge, `offset` becomes 0x800: bit 11 set and bits 10:0 zero.
- R8: `done` clears in the cycle after `start_eval` is seen low, and `offset` keeps its value.
- R9: If `start_eval` falls before `done` rises, the measurement is abandoned and `done` stays low.
- R10: After reset, `done` is 0, `offset` is 0 and `fmt_gci` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the serial bit-clock rate (one cycle per master-clock half-period) |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_in | input | 1 | 8 kHz frame pulse, either polarity |
| fe_in | input | 1 | Frame-evaluation input to be measured |
| start_eval | input | 1 | Start bit that arms and launches a measurement |
| fmt_gci | output | 1 | Detected convention: 0 = ST-BUS (active low), 1 = GCI (active high) |
| offset | output | OFS_W | Bits 10:0 hold the cycle count; bit 11 flags a missing evaluation edge |
| done | output | 1 | Measurement complete flag |

## Verification
The bench builds the unit with `FRAME_LEN` = 40 and one sampling stage. This is short enough to sweep the evaluation edge over every position of the frame, zero and the last cycle included, in both conventions. Each sweep step checks the exact completion cycle against the arithmetic 2·40 − p + 2 for a start rise at frame position p. The small frame also makes it cheap to hit the remaining corners: the one-cycle-short arming period, an abort in mid-measurement, an exactly balanced pulse for format detection, opposite-polarity evaluation pulses, and frames with no evaluation edge.

// File: rtl/fom_pkg.sv
package fom_pkg;

    typedef enum logic [2:0] {
        ST_BLOCKED,
        ST_COUNT_LOW,
        ST_ARMED,
        ST_SYNC,
        ST_MEASURE,
        ST_HOLD,
        ST_DONE
    } meas_state_e;

    typedef enum logic {
        FMT_STBUS = 1'b0,
        FMT_GCI   = 1'b1
    } fp_format_e;

endpackage

// File: rtl/fom_edge_sense.sv
module fom_edge_sense #(
    parameter int   SAMPLE_STAGES = 1,
    parameter logic IDLE_LEVEL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic want_rise,
    output logic hit
);
    logic [SAMPLE_STAGES:0] pipe;
    logic                   cur;
    logic                   prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {(SAMPLE_STAGES + 1){IDLE_LEVEL}};
        end else begin
            pipe <= {pipe[SAMPLE_STAGES-1:0], din};
        end
    end

    assign cur  = pipe[SAMPLE_STAGES-1];
    assign prev = pipe[SAMPLE_STAGES];

    // Polarity chosen by the detected frame convention.
    always_comb begin
        if (want_rise) begin
            hit = cur & ~prev;
        end else begin
            hit = ~cur & prev;
        end
    end
endmodule

// File: rtl/fom_fmt_detect.sv
module fom_fmt_detect
    import fom_pkg::*;
#(
    parameter int FRAME_LEN = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fp_raw,
    output fp_format_e fmt
);
    localparam int WIN_W = $clog2(FRAME_LEN);
    localparam int HI_W  = $clog2(FRAME_LEN + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(FRAME_LEN - 1);
    localparam logic [HI_W:0]    HALF_REF = (HI_W + 1)'(FRAME_LEN);

    logic             level;
    logic [WIN_W-1:0] win_cnt;
    logic [HI_W-1:0]  hi_cnt;
    logic [HI_W-1:0]  hi_total;
    logic [HI_W:0]    hi_twice;

    assign hi_total = hi_cnt + HI_W'(level);
    assign hi_twice = {hi_total, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level   <= 1'b1;
            win_cnt <= '0;
            hi_cnt  <= '0;
            fmt     <= FMT_STBUS;
        end else begin
            level <= fp_raw;
            if (win_cnt == WIN_LAST) begin
                win_cnt <= '0;
                hi_cnt  <= '0;
                // Majority idle level decides; a tie keeps the old decision.
                if (hi_twice > HALF_REF) begin
                    fmt <= FMT_STBUS;
                end else if (hi_twice < HALF_REF) begin
                    fmt <= FMT_GCI;
                end
            end else begin
                win_cnt <= win_cnt + 1'b1;
                hi_cnt  <= hi_total;
            end
        end
    end
endmodule

// File: rtl/fom_meas_fsm.sv
module fom_meas_fsm
    import fom_pkg::*;
#(
    parameter int FRAME_LEN = 1024,
    parameter int OFS_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             frame_hit,
    input  logic             fe_hit,
    output logic [OFS_W-1:0] offset,
    output logic             done
);
    localparam int CNT_W = OFS_W - 1;
    localparam int LOW_W = $clog2(FRAME_LEN + 1);
    localparam logic [LOW_W-1:0] LOW_FULL  = LOW_W'(FRAME_LEN);
    localparam logic [LOW_W-1:0] LOW_ENUF  = LOW_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [OFS_W-1:0] MISS_CODE = {1'b1, {CNT_W{1'b0}}};

    meas_state_e      state;
    meas_state_e      nxt;
    logic [LOW_W-1:0] low_cnt;
    logic [CNT_W-1:0] cnt;
    logic             long_low;
    logic             cap_en;
    logic [OFS_W-1:0] cap_val;

    assign long_low = (low_cnt >= LOW_ENUF);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BLOCKED;
        end else begin
            state <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_BLOCKED: begin
                if (!start) nxt = ST_COUNT_LOW;
            end
            ST_COUNT_LOW: begin
                if (start) begin
                    nxt = ST_BLOCKED;
                end else if (long_low) begin
                    nxt = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (start) nxt = ST_SYNC;
            end
            ST_SYNC: begin
                if (!start) begin
                    nxt = ST_COUNT_LOW;
                end else if (frame_hit) begin
                    nxt = fe_hit ? ST_HOLD : ST_MEASURE;
                end
            end
            ST_MEASURE: begin
                if (!start) begin
                    nxt = ST_COUNT_LOW;
                end else if (frame_hit) begin
                    nxt = ST_DONE;
                end else if (fe_hit) begin
                    nxt = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!start) begin
                    nxt = ST_COUNT_LOW;
                end else if (frame_hit) begin
                    nxt = ST_DONE;
                end
            end
            ST_DONE: begin
                if (!start) nxt = ST_COUNT_LOW;
            end
            default: nxt = ST_BLOCKED;
        endcase
    end

    // Outputs and capture control
    always_comb begin
        done    = (state == ST_DONE);
        cap_en  = 1'b0;
        cap_val = '0;
        unique case (state)
            ST_SYNC: begin
                if (start && frame_hit && fe_hit) begin
                    cap_en  = 1'b1;
                    cap_val = '0;
                end
            end
            ST_MEASURE: begin
                if (start && fe_hit) begin
                    cap_en  = 1'b1;
                    cap_val = {1'b0, cnt};
                end else if (start && frame_hit) begin
                    cap_en  = 1'b1;
                    cap_val = MISS_CODE;
                end
            end
            default: begin
                cap_en  = 1'b0;
                cap_val = '0;
            end
        endcase
    end

    // Datapath: low-period counter, offset counter, result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            cnt     <= '0;
            offset  <= '0;
        end else begin
            if (start) begin
                low_cnt <= '0;
            end else if (low_cnt != LOW_FULL) begin
                low_cnt <= low_cnt + 1'b1;
            end

            if (state == ST_SYNC) begin
                cnt <= CNT_W'(1);
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end

            if (cap_en) begin
                offset <= cap_val;
            end
        end
    end
endmodule

// File: rtl/fom_unit.sv
module fom_unit
    import fom_pkg::*;
#(
    parameter int FRAME_LEN     = 1024,
    parameter int OFS_W         = 12,
    parameter int SAMPLE_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_in,
    input  logic             fe_in,
    input  logic             start_eval,
    output logic             fmt_gci,
    output logic [OFS_W-1:0] offset,
    output logic             done
);
    fp_format_e fmt;
    logic       want_rise;
    logic       frame_hit;
    logic       fe_hit;

    assign want_rise = (fmt == FMT_GCI);
    assign fmt_gci   = want_rise;

    fom_fmt_detect #(
        .FRAME_LEN(FRAME_LEN)
    ) u_fmt (
        .clk   (clk),
        .rst_n (rst_n),
        .fp_raw(fp_in),
        .fmt   (fmt)
    );

    fom_edge_sense #(
        .SAMPLE_STAGES(SAMPLE_STAGES),
        .IDLE_LEVEL   (1'b1)
    ) u_fp_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (fp_in),
        .want_rise(want_rise),
        .hit      (frame_hit)
    );

    fom_edge_sense #(
        .SAMPLE_STAGES(SAMPLE_STAGES),
        .IDLE_LEVEL   (1'b1)
    ) u_fe_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (fe_in),
        .want_rise(want_rise),
        .hit      (fe_hit)
    );

    fom_meas_fsm #(
        .FRAME_LEN(FRAME_LEN),
        .OFS_W    (OFS_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_eval),
        .frame_hit(frame_hit),
        .fe_hit   (fe_hit),
        .offset   (offset),
        .done     (done)
    );
endmodule

// File: rtl/fom_unit_chk.sv
module fom_unit_chk #(
    parameter int FRAME_LEN = 1024,
    parameter int OFS_W     = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_eval,
    input logic             fmt_gci,
    input logic [OFS_W-1:0] offset,
    input logic             done
);
    localparam logic [OFS_W-2:0] OFS_LIMIT = (OFS_W - 1)'(FRAME_LEN);

    // R1: the format decision moves at most once per window, never on back-to-back cycles
    assert_fmt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_gci != $past(fmt_gci)) |=> (fmt_gci == $past(fmt_gci)));

    // R3: completion can only begin while the start bit is high
    assert_rise_with_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> start_eval);

    // R5: a counted result never exceeds one frame
    assert_offset_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !offset[OFS_W-1]) |-> (offset[OFS_W-2:0] <= OFS_LIMIT));

    // R7: the missing-edge code carries a zero count
    assert_missing_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        offset[OFS_W-1] |-> (offset[OFS_W-2:0] == '0));

    // R8: a low start bit clears completion on the next cycle
    assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_eval) |=> !done);

    // R8: the result is not disturbed while the start bit is low
    assert_offset_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_eval |=> $stable(offset));

    // R9: no completion appears while the start bit is low
    assert_no_spont_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_eval && !done) |=> !done);
endmodule

bind fom_unit fom_unit_chk #(
    .FRAME_LEN(FRAME_LEN),
    .OFS_W    (OFS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_eval(start_eval),
    .fmt_gci   (fmt_gci),
    .offset    (offset),
    .done      (done)
);

// File: tb/fom_unit_test.sv
`timescale 1ns/1ps
module fom_unit_test;
    localparam int FL = 40;
    localparam int OW = 12;
    localparam int P0 = FL / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fp_in = 1'b1;
    logic          fe_in = 1'b1;
    logic          start_eval = 1'b1;
    logic          fmt_gci;
    logic [OW-1:0] offset;
    logic          done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int pos       = FL - 1;
    bit gci_mode  = 0;
    bit half_mode = 0;
    bit fe_en     = 1;
    bit fe_inv    = 0;
    int fe_ofs    = 0;

    always #4 clk = ~clk;

    fom_unit #(.FRAME_LEN(FL), .OFS_W(OW), .SAMPLE_STAGES(1)) uut (
        .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .fe_in(fe_in),
        .start_eval(start_eval), .fmt_gci(fmt_gci), .offset(offset), .done(done)
    );

    // Frame generator: drives pulses on the falling clock edge.
    always @(negedge clk) begin
        bit fa;
        bit fe_hi;
        pos = (pos == FL - 1) ? 0 : pos + 1;
        if (half_mode) fp_in = (pos < FL / 2) ? 1'b1 : 1'b0;
        else if (gci_mode) fp_in = (pos < 2) ? 1'b1 : 1'b0;
        else fp_in = (pos < 2) ? 1'b0 : 1'b1;
        fa = fe_en && (pos >= fe_ofs) && (pos <= fe_ofs + 1);
        fe_hi = gci_mode ^ fe_inv;
        fe_in = (fe_hi ? fa : !fa) ? 1'b1 : 1'b0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Arm with low_len low cycles, raise start at frame position P0, observe.
    task automatic run_meas(input int low_len, input bit exp_done, input int exp_ofs, input string req);
        int got;
        @(posedge clk);
        while (pos != P0 - 1) @(posedge clk);
        @(negedge clk);
        start_eval = 1'b0;
        repeat (low_len) @(negedge clk);
        start_eval = 1'b1;
        got = -1;
        for (int k = 1; k <= 3 * FL; k++) begin
            @(negedge clk);
            #1;
            if (done) begin
                got = k;
                break;
            end
        end
        if (exp_done) begin
            chk(got == 2 * FL - P0 + 2, "R4", got, 2 * FL - P0 + 2);
            chk(offset == OW'(exp_ofs), req, int'(offset), exp_ofs);
            @(negedge clk);
            start_eval = 1'b0;
            @(negedge clk);
            #1;
            chk(!done, "R8", int'(done), 0);
            chk(offset == OW'(exp_ofs), "R8", int'(offset), exp_ofs);
            @(negedge clk);
            start_eval = 1'b1;
        end else begin
            chk(got < 0, req, got, -1);
        end
    endtask

    task automatic settle_fmt(input int n);
        @(posedge clk);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(done == 1'b0, "R10", int'(done), 0);
        chk(offset == '0, "R10", int'(offset), 0);
        chk(fmt_gci == 1'b0, "R10", int'(fmt_gci), 0);

        settle_fmt(2 * FL + 3);
        chk(fmt_gci == 1'b0, "R1", int'(fmt_gci), 0);

        // ST-BUS: evaluation edge at every frame position
        for (int o = 0; o < FL; o++) begin
            fe_ofs = o;
            run_meas(FL, 1, o, "R5");
        end

        // ST-BUS: rising evaluation pulse, only its trailing falling edge counts
        fe_ofs = 7;
        fe_inv = 1;
        run_meas(FL, 1, 9, "R6");
        fe_inv = 0;

        // No evaluation edge at all
        fe_en = 0;
        run_meas(FL, 1, 12'h800, "R7");
        fe_en = 1;

        // Start low one cycle too short: ignored; exactly one frame: launches
        fe_ofs = 11;
        run_meas(FL - 1, 0, 0, "R3");
        run_meas(FL, 1, 11, "R3");

        // Abort in mid-measurement
        @(posedge clk);
        while (pos != P0 - 1) @(posedge clk);
        @(negedge clk);
        start_eval = 1'b0;
        repeat (FL) @(negedge clk);
        start_eval = 1'b1;
        repeat (FL) @(negedge clk);
        start_eval = 1'b0;
        begin
            bit seen = 0;
            for (int k = 0; k < 3 * FL; k++) begin
                @(negedge clk);
                #1;
                if (done) seen = 1;
            end
            chk(!seen, "R9", int'(seen), 0);
        end
        @(negedge clk);
        start_eval = 1'b1;

        // Balanced frame pulse keeps ST-BUS
        @(posedge clk);
        half_mode = 1;
        settle_fmt(3 * FL);
        chk(fmt_gci == 1'b0, "R2", int'(fmt_gci), 0);

        // Switch to GCI
        @(posedge clk);
        half_mode = 0;
        gci_mode = 1;
        settle_fmt(2 * FL + 3);
        chk(fmt_gci == 1'b1, "R1", int'(fmt_gci), 1);

        for (int o = 0; o < FL; o++) begin
            fe_ofs = o;
            run_meas(FL, 1, o, "R6");
        end

        fe_ofs = 4;
        fe_inv = 1;
        run_meas(FL, 1, 6, "R6");
        fe_inv = 0;

        fe_en = 0;
        run_meas(FL, 1, 12'h800, "R7");
        fe_en = 1;

        // Balanced frame pulse keeps GCI
        @(posedge clk);
        half_mode = 1;
        settle_fmt(3 * FL);
        chk(fmt_gci == 1'b1, "R2", int'(fmt_gci), 1);

        // Back to ST-BUS
        @(posedge clk);
        half_mode = 0;
        gci_mode = 0;
        settle_fmt(2 * FL + 3);
        chk(fmt_gci == 1'b0, "R1", int'(fmt_gci), 0);

        fe_ofs = 3;
        run_meas(FL, 1, 3, "R5");

        finish_run();
    end
endmodule